// File: doc/BRIEF.md
# Frame-Synchronized Command Sequencer

This block holds register-write commands until a chosen video frame and then replays them. It keeps one command queue for each of 16 frame slots, arranged as a ring. A 4-bit frame counter steps on every frame-sync pulse while the block runs. Each time it steps, the queue of the slot it lands on is replayed in order on a register-write output port, one write per clock.

A host places a command with two writes that both name a slot. The first write carries the target register address and the second carries the data. A slot is named in one of two ways: as an absolute frame number 0 to 15, or as an offset 1 to 14 ahead of the current frame. Offset 0 is not queued. The command is issued as soon as possible, ahead of any replay in progress. Relative location 15 is not a slot. It is the control register, which clears the block, starts it or stops it. While stopped, the block still accepts and stores commands, but it issues none and ignores frame sync.

Top module: `frame_cmd_sequencer`

## Requirements
- R1: After `rst_n` is released, `cur_frame` is 0, `seq_running` is 0, `cmd_overflow` is 0 and `out_we` is 0.
- R2: Two host writes to any location other than the control register form one command. The low `ADDR_W` bits of the first word become `out_addr` and the whole second word becomes `out_data`.
- R3: With `host_rel`=0, `host_slot` names an absolute frame 0..15. The command is issued only after a frame sync that makes `cur_frame` equal to that number, including after the counter wraps from 15 to 0.
- R4: With `host_rel`=1 and `host_slot`=k (1..14), the command goes to frame (`cur_frame`+k) mod 16, taking `cur_frame` at the time of the address write.
- R5: With `host_rel`=1 and `host_slot`=0, a running block puts the command on `out_we`/`out_addr`/`out_data` in the cycle after the clock edge that takes the data write.
- R6: A single write with `host_rel`=1 and `host_slot`=15 is a control write. Bit 0 clears: it empties all queues, drops any held immediate command, sets `cur_frame` to 0, clears `cmd_overflow` and stops the block. Bit 0 wins over the other bits. Bit 1 enables a run-state change, and bit 2 gives the new run state (1 runs, 0 stops).
- R7: A frame sync while running advances `cur_frame` by one, modulo 16. A frame sync while stopped leaves `cur_frame` unchanged.
- R8: The commands of the slot reached by a frame sync are issued in the order they were written, one per cycle. The first is issued in the cycle after the sync edge, and the slot is left empty.
- R9: While stopped, `out_we` stays 0. An immediate command written while stopped is held and is issued one cycle after the control write that starts the block.
- R10: Each slot holds at most `QDEPTH` commands. A further command for a full slot is dropped, as is a second immediate command while one is still held, and either drop sets `cmd_overflow`. `cmd_overflow` stays set until a clear.
- R11: When an immediate command and a replay want the port in the same cycle, the immediate command is issued first and the replay resumes one cycle later without losing an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| host_we | input | 1 | Host write strobe |
| host_rel | input | 1 | 1: `host_slot` is an offset from the current frame; 0: absolute frame |
| host_slot | input | SLOT_BITS | Frame number or offset; relative 15 selects the control register |
| host_word | input | DATA_W | Address word, data word or control word |
| frame_sync | input | 1 | One-cycle frame start pulse |
| out_we | output | 1 | Register-write strobe toward the register fabric |
| out_addr | output | ADDR_W | Register address of the issued command |
| out_data | output | DATA_W | Data of the issued command |
| cur_frame | output | SLOT_BITS | Current frame number |
| seq_running | output | 1 | Run state |
| cmd_overflow | output | 1 | Sticky flag: a command was dropped |

## Verification
The immediate path and the replay of a slot are the two functions that can claim the output port in the same cycle. The bench queues three commands in the next slot and sends the address half of an immediate command. It then pulses frame sync and delivers the data half on the very next edge, so the held immediate command becomes ready while the replay has issued only its first entry. The port is judged cycle by cycle: first queue entry, then the immediate command, then the two remaining entries, then silence. No entry may be lost or repeated.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
   // control word bit positions (relative location 15)
   localparam int CTL_CLEAR_BIT   = 0;
   localparam int CTL_RUN_EN_BIT  = 1;
   localparam int CTL_RUN_VAL_BIT = 2;

   typedef struct packed {
      logic clear;
      logic run_en;
      logic run_val;
   } fcs_ctl_t;
endpackage

// File: rtl/fcs_host_decode.sv
module fcs_host_decode #(
   parameter int SLOT_BITS = 4,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_we,
   input  logic                 host_rel,
   input  logic [SLOT_BITS-1:0] host_slot,
   input  logic [DATA_W-1:0]    host_word,
   input  logic [SLOT_BITS-1:0] cur_frame,
   output logic                 push_valid,
   output logic                 push_imm,
   output logic [SLOT_BITS-1:0] push_slot,
   output logic [ADDR_W-1:0]    push_addr,
   output logic [DATA_W-1:0]    push_data,
   output logic                 ctl_valid,
   output fcs_pkg::fcs_ctl_t    ctl
);
   logic                 phase_q;   // 1: address word captured, data expected
   logic                 imm_q;
   logic [SLOT_BITS-1:0] slot_q;
   logic [ADDR_W-1:0]    addr_q;
   logic                 is_ctl;
   logic                 pair_done;

   assign is_ctl      = host_rel && (host_slot == {SLOT_BITS{1'b1}});
   assign ctl_valid   = host_we && is_ctl;
   assign ctl.clear   = host_word[fcs_pkg::CTL_CLEAR_BIT];
   assign ctl.run_en  = host_word[fcs_pkg::CTL_RUN_EN_BIT];
   assign ctl.run_val = host_word[fcs_pkg::CTL_RUN_VAL_BIT];

   assign pair_done  = host_we && !is_ctl && phase_q;
   assign push_valid = pair_done && !imm_q;
   assign push_imm   = pair_done && imm_q;
   assign push_slot  = slot_q;
   assign push_addr  = addr_q;
   assign push_data  = host_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         imm_q   <= 1'b0;
         slot_q  <= '0;
         addr_q  <= '0;
      end else if (ctl_valid && ctl.clear) begin
         phase_q <= 1'b0;
      end else if (host_we && !is_ctl) begin
         if (!phase_q) begin
            addr_q  <= host_word[ADDR_W-1:0];
            imm_q   <= host_rel && (host_slot == '0);
            slot_q  <= host_rel ? (cur_frame + host_slot) : host_slot;
            phase_q <= 1'b1;
         end else begin
            phase_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fcs_slot_store.sv
module fcs_slot_store #(
   parameter int SLOT_BITS = 4,
   parameter int QDEPTH    = 16,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_all,
   input  logic                 clr_en,
   input  logic [SLOT_BITS-1:0] clr_slot,
   input  logic                 push_valid,
   input  logic [SLOT_BITS-1:0] push_slot,
   input  logic [ADDR_W-1:0]    push_addr,
   input  logic [DATA_W-1:0]    push_data,
   input  logic [SLOT_BITS-1:0] rd_slot,
   input  logic [((QDEPTH > 1) ? $clog2(QDEPTH) : 1)-1:0] rd_idx,
   output logic [$clog2(QDEPTH+1)-1:0] rd_cnt,
   output logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 drop
);
   localparam int SLOTS  = 1 << SLOT_BITS;
   localparam int IDX_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
   localparam int CNT_W  = $clog2(QDEPTH+1);
   localparam int MEM_N  = SLOTS * QDEPTH;
   localparam int MEM_W  = (MEM_N > 1) ? $clog2(MEM_N) : 1;
   localparam bit POW2   = (QDEPTH > 1) && ((QDEPTH & (QDEPTH - 1)) == 0);

   logic [CNT_W-1:0]  cnt_w [SLOTS];
   logic [ADDR_W-1:0] mem_a [MEM_N];
   logic [DATA_W-1:0] mem_d [MEM_N];
   logic [CNT_W-1:0]  wr_base;
   logic              push_ok;
   logic [MEM_W-1:0]  wr_ptr;
   logic [MEM_W-1:0]  rd_ptr;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [CNT_W-1:0] cnt_r;
      logic [CNT_W-1:0] base;
      assign base     = (clr_en && (clr_slot == SLOT_BITS'(s))) ? '0 : cnt_r;
      assign cnt_w[s] = cnt_r;
      always_ff @(posedge clk) begin
         if (!rst_n || clr_all)
            cnt_r <= '0;
         else if (push_ok && (push_slot == SLOT_BITS'(s)))
            cnt_r <= base + 1'b1;
         else
            cnt_r <= base;
      end
   end

   assign wr_base = (clr_en && (clr_slot == push_slot)) ? '0 : cnt_w[push_slot];
   assign push_ok = push_valid && !clr_all && (wr_base != CNT_W'(QDEPTH));
   assign drop    = push_valid && !clr_all && (wr_base == CNT_W'(QDEPTH));

   if (POW2) begin : g_ptr_cat
      assign wr_ptr = {push_slot, wr_base[IDX_W-1:0]};
      assign rd_ptr = {rd_slot, rd_idx};
   end else begin : g_ptr_mul
      assign wr_ptr = MEM_W'(int'(push_slot) * QDEPTH + int'(wr_base));
      assign rd_ptr = MEM_W'(int'(rd_slot) * QDEPTH + int'(rd_idx));
   end

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem_a[wr_ptr] <= push_addr;
         mem_d[wr_ptr] <= push_data;
      end
   end

   assign rd_cnt  = cnt_w[rd_slot];
   assign rd_addr = mem_a[rd_ptr];
   assign rd_data = mem_d[rd_ptr];
endmodule

// File: rtl/fcs_issue.sv
module fcs_issue #(
   parameter int SLOT_BITS = 4,
   parameter int QDEPTH    = 16,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_sync,
   input  logic                 ctl_valid,
   input  fcs_pkg::fcs_ctl_t    ctl,
   input  logic                 push_imm,
   input  logic [ADDR_W-1:0]    imm_addr,
   input  logic [DATA_W-1:0]    imm_data,
   input  logic [$clog2(QDEPTH+1)-1:0] rd_cnt,
   input  logic [ADDR_W-1:0]    rd_addr,
   input  logic [DATA_W-1:0]    rd_data,
   input  logic                 store_drop,
   output logic [((QDEPTH > 1) ? $clog2(QDEPTH) : 1)-1:0] rd_idx,
   output logic                 clr_all,
   output logic                 clr_en,
   output logic [SLOT_BITS-1:0] clr_slot,
   output logic                 out_we,
   output logic [ADDR_W-1:0]    out_addr,
   output logic [DATA_W-1:0]    out_data,
   output logic [SLOT_BITS-1:0] cur_frame,
   output logic                 running,
   output logic                 overflow
);
   localparam int IDX_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
   localparam int CNT_W = $clog2(QDEPTH+1);

   logic [SLOT_BITS-1:0] cur_q;
   logic                 run_q;
   logic                 drain_q;
   logic [CNT_W-1:0]     idx_q;
   logic                 imm_hold_q;
   logic [ADDR_W-1:0]    imm_addr_q;
   logic [DATA_W-1:0]    imm_data_q;
   logic                 ovf_q;
   logic                 clear;
   logic                 run_next;
   logic                 imm_go;
   logic                 sync_go;
   logic                 drain_act;
   logic                 drain_go;
   logic                 drain_end;

   assign clear     = ctl_valid && ctl.clear;
   assign run_next  = (ctl_valid && ctl.run_en) ? ctl.run_val : run_q;
   assign imm_go    = imm_hold_q && run_q;
   assign sync_go   = frame_sync && run_q;
   assign drain_act = drain_q && run_q;
   assign drain_go  = drain_act && !sync_go && !imm_go && (idx_q < rd_cnt);
   assign drain_end = drain_act && (sync_go || (idx_q == rd_cnt));

   assign clr_all   = clear;
   assign clr_en    = drain_end;
   assign clr_slot  = cur_q;
   assign rd_idx    = idx_q[IDX_W-1:0];
   assign cur_frame = cur_q;
   assign running   = run_q;
   assign overflow  = ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cur_q      <= '0;
         run_q      <= 1'b0;
         drain_q    <= 1'b0;
         idx_q      <= '0;
         imm_hold_q <= 1'b0;
         ovf_q      <= 1'b0;
         out_we     <= 1'b0;
         if (!rst_n) begin
            imm_addr_q <= '0;
            imm_data_q <= '0;
            out_addr   <= '0;
            out_data   <= '0;
         end
      end else begin
         run_q  <= run_next;
         out_we <= imm_go || drain_go;
         if (imm_go) begin
            out_addr <= imm_addr_q;
            out_data <= imm_data_q;
         end else if (drain_go) begin
            out_addr <= rd_addr;
            out_data <= rd_data;
         end

         if (sync_go) begin
            cur_q   <= cur_q + 1'b1;
            drain_q <= 1'b1;
            idx_q   <= '0;
         end else if (drain_end) begin
            drain_q <= 1'b0;
         end else if (drain_go) begin
            idx_q <= idx_q + 1'b1;
         end

         if (push_imm) begin
            if (imm_hold_q && !imm_go) begin
               ovf_q <= 1'b1;
            end else begin
               imm_hold_q <= 1'b1;
               imm_addr_q <= imm_addr;
               imm_data_q <= imm_data;
            end
         end else if (imm_go) begin
            imm_hold_q <= 1'b0;
         end

         if (store_drop)
            ovf_q <= 1'b1;
      end
   end
endmodule

// File: rtl/frame_cmd_sequencer.sv
module frame_cmd_sequencer #(
   parameter int SLOT_BITS = 4,
   parameter int QDEPTH    = 16,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_we,
   input  logic                 host_rel,
   input  logic [SLOT_BITS-1:0] host_slot,
   input  logic [DATA_W-1:0]    host_word,
   input  logic                 frame_sync,
   output logic                 out_we,
   output logic [ADDR_W-1:0]    out_addr,
   output logic [DATA_W-1:0]    out_data,
   output logic [SLOT_BITS-1:0] cur_frame,
   output logic                 seq_running,
   output logic                 cmd_overflow
);
   localparam int IDX_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
   localparam int CNT_W = $clog2(QDEPTH+1);

   if (SLOT_BITS < 2) begin : g_bad_slots
      $error("SLOT_BITS must be at least 2");
   end
   if (QDEPTH < 1) begin : g_bad_depth
      $error("QDEPTH must be at least 1");
   end
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("ADDR_W must not exceed DATA_W");
   end
   if (DATA_W < 3) begin : g_bad_data
      $error("DATA_W must hold the control bits");
   end

   logic                 push_valid;
   logic                 push_imm;
   logic [SLOT_BITS-1:0] push_slot;
   logic [ADDR_W-1:0]    push_addr;
   logic [DATA_W-1:0]    push_data;
   logic                 ctl_valid;
   fcs_pkg::fcs_ctl_t    ctl;
   logic                 clr_all;
   logic                 clr_en;
   logic [SLOT_BITS-1:0] clr_slot;
   logic [IDX_W-1:0]     rd_idx;
   logic [CNT_W-1:0]     rd_cnt;
   logic [ADDR_W-1:0]    rd_addr;
   logic [DATA_W-1:0]    rd_data;
   logic                 store_drop;

   fcs_host_decode #(.SLOT_BITS(SLOT_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_rel(host_rel),
      .host_slot(host_slot), .host_word(host_word), .cur_frame(cur_frame),
      .push_valid(push_valid), .push_imm(push_imm), .push_slot(push_slot),
      .push_addr(push_addr), .push_data(push_data),
      .ctl_valid(ctl_valid), .ctl(ctl));

   fcs_slot_store #(.SLOT_BITS(SLOT_BITS), .QDEPTH(QDEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .clr_en(clr_en), .clr_slot(clr_slot),
      .push_valid(push_valid), .push_slot(push_slot), .push_addr(push_addr),
      .push_data(push_data), .rd_slot(cur_frame), .rd_idx(rd_idx),
      .rd_cnt(rd_cnt), .rd_addr(rd_addr), .rd_data(rd_data), .drop(store_drop));

   fcs_issue #(.SLOT_BITS(SLOT_BITS), .QDEPTH(QDEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
      .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ctl_valid(ctl_valid), .ctl(ctl),
      .push_imm(push_imm), .imm_addr(push_addr), .imm_data(push_data),
      .rd_cnt(rd_cnt), .rd_addr(rd_addr), .rd_data(rd_data), .store_drop(store_drop),
      .rd_idx(rd_idx), .clr_all(clr_all), .clr_en(clr_en), .clr_slot(clr_slot),
      .out_we(out_we), .out_addr(out_addr), .out_data(out_data),
      .cur_frame(cur_frame), .running(seq_running), .overflow(cmd_overflow));
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
   parameter int SLOT_BITS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 host_we,
   input logic                 host_rel,
   input logic [SLOT_BITS-1:0] host_slot,
   input logic                 host_word0,
   input logic                 frame_sync,
   input logic                 out_we,
   input logic [SLOT_BITS-1:0] cur_frame,
   input logic                 seq_running,
   input logic                 cmd_overflow
);
   logic ctl_clr;
   assign ctl_clr = host_we && host_rel && (&host_slot) && host_word0;

   // R6: a clear leaves the block stopped at frame 0 with no overflow
   a_r6_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_clr |=> (!seq_running && (cur_frame == '0) && !cmd_overflow));

   // R7: a sync while running steps the frame counter by one
   a_r7_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_sync && seq_running && !ctl_clr) |=> (cur_frame == $past(cur_frame) + 1'b1));

   // R7: no running sync, no frame change
   a_r7_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(frame_sync && seq_running) && !ctl_clr) |=> $stable(cur_frame));

   // R9: nothing is issued by a stopped block
   a_r9_stopped_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_running |=> !out_we);

   // R10: overflow stays set until a clear
   a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_overflow && !ctl_clr) |=> cmd_overflow);
endmodule

bind frame_cmd_sequencer fcs_checker #(.SLOT_BITS(SLOT_BITS)) u_fcs_checker (
   .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_rel(host_rel),
   .host_slot(host_slot), .host_word0(host_word[0]), .frame_sync(frame_sync),
   .out_we(out_we), .cur_frame(cur_frame), .seq_running(seq_running),
   .cmd_overflow(cmd_overflow));

// File: tb/frame_cmd_sequencer_bench.sv
module frame_cmd_sequencer_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        host_we;
   logic        host_rel;
   logic [3:0]  host_slot;
   logic [31:0] host_word;
   logic        frame_sync;
   logic        out_we;
   logic [15:0] out_addr;
   logic [31:0] out_data;
   logic [3:0]  cur_frame;
   logic        seq_running;
   logic        cmd_overflow;
   int          checks = 0;
   int          errors = 0;

   always #2.5 clk = ~clk;

   frame_cmd_sequencer u_frame_cmd_sequencer (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_rel(host_rel),
      .host_slot(host_slot), .host_word(host_word), .frame_sync(frame_sync),
      .out_we(out_we), .out_addr(out_addr), .out_data(out_data),
      .cur_frame(cur_frame), .seq_running(seq_running), .cmd_overflow(cmd_overflow));

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_issue(input string req, input logic [15:0] a, input logic [31:0] d);
      check(req, {63'd0, out_we}, 64'd1);
      check(req, {48'd0, out_addr}, {48'd0, a});
      check(req, {32'd0, out_data}, {32'd0, d});
   endtask

   task automatic hw(input logic rel, input logic [3:0] slot, input logic [31:0] word);
      host_we = 1'b1; host_rel = rel; host_slot = slot; host_word = word;
      step();
      host_we = 1'b0;
   endtask

   task automatic cmd(input logic rel, input logic [3:0] slot, input logic [15:0] a, input logic [31:0] d);
      hw(rel, slot, {16'd0, a});
      hw(rel, slot, d);
   endtask

   task automatic ctl(input logic [31:0] w);
      hw(1'b1, 4'hF, w);
   endtask

   task automatic sync();
      frame_sync = 1'b1;
      step();
      frame_sync = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 frame", {60'd0, cur_frame}, 64'd0);
      check("R1 running", {63'd0, seq_running}, 64'd0);
      check("R1 overflow", {63'd0, cmd_overflow}, 64'd0);
      check("R1 out_we", {63'd0, out_we}, 64'd0);
   endtask

   task automatic t_run();
      ctl(32'h6);
      check("R6 run", {63'd0, seq_running}, 64'd1);
   endtask

   task automatic t_absolute();
      cmd(1'b0, 4'd1, 16'h0011, 32'hA1);
      cmd(1'b0, 4'd1, 16'h0012, 32'hA2);
      check("R3 held", {63'd0, out_we}, 64'd0);
      sync();
      check("R7 step", {60'd0, cur_frame}, 64'd1);
      check("R8 sync edge", {63'd0, out_we}, 64'd0);
      step(); check_issue("R2 R8 first", 16'h0011, 32'hA1);
      step(); check_issue("R8 second", 16'h0012, 32'hA2);
      step(); check("R8 drained", {63'd0, out_we}, 64'd0);
   endtask

   task automatic t_relative();
      cmd(1'b1, 4'd2, 16'h0033, 32'hC3);
      sync(); step();
      check("R4 not frame 2", {63'd0, out_we}, 64'd0);
      step();
      check("R4 not frame 2", {63'd0, out_we}, 64'd0);
      sync(); step();
      check_issue("R4 frame 3", 16'h0033, 32'hC3);
      step();
   endtask

   task automatic t_immediate();
      cmd(1'b1, 4'd0, 16'h0055, 32'h5555);
      check("R5 edge", {63'd0, out_we}, 64'd0);
      step(); check_issue("R5 issue", 16'h0055, 32'h5555);
      step(); check("R5 once", {63'd0, out_we}, 64'd0);
   endtask

   task automatic t_wrap();
      int seen = 0;
      cmd(1'b0, 4'd0, 16'h0060, 32'h66);
      for (int i = 0; i < 12; i++) begin
         sync(); step();
         if (out_we) seen++;
      end
      check("R3 early", seen, 0);
      check("R7 at 15", {60'd0, cur_frame}, 64'd15);
      sync();
      check("R7 wrap", {60'd0, cur_frame}, 64'd0);
      step(); check_issue("R3 wrap", 16'h0060, 32'h66);
      step();
   endtask

   task automatic t_stopped();
      int seen = 0;
      ctl(32'h2);
      check("R6 stop", {63'd0, seq_running}, 64'd0);
      cmd(1'b1, 4'd0, 16'h0077, 32'h777);
      for (int i = 0; i < 3; i++) begin
         step();
         if (out_we) seen++;
      end
      check("R9 silent", seen, 0);
      sync();
      check("R7 ignored", {60'd0, cur_frame}, 64'd0);
      ctl(32'h6);
      check("R9 run edge", {63'd0, out_we}, 64'd0);
      step(); check_issue("R9 held imm", 16'h0077, 32'h777);
      step();
   endtask

   task automatic t_overflow();
      int bad = 0;
      for (int i = 0; i < 17; i++) cmd(1'b0, 4'd1, 16'(i), 32'h100 + i);
      check("R10 flag", {63'd0, cmd_overflow}, 64'd1);
      sync();
      for (int i = 0; i < 16; i++) begin
         step();
         if (!out_we || out_addr != 16'(i) || out_data != 32'h100 + i) bad++;
      end
      check("R10 kept order", bad, 0);
      step(); check("R10 dropped", {63'd0, out_we}, 64'd0);
      check("R10 sticky", {63'd0, cmd_overflow}, 64'd1);
      ctl(32'h7);
      check("R6 clear ovf", {63'd0, cmd_overflow}, 64'd0);
      check("R6 clear frame", {60'd0, cur_frame}, 64'd0);
      check("R6 clear wins", {63'd0, seq_running}, 64'd0);
      ctl(32'h6);
   endtask

   task automatic t_priority();
      cmd(1'b0, 4'd1, 16'h0091, 32'h91);
      cmd(1'b0, 4'd1, 16'h0092, 32'h92);
      cmd(1'b0, 4'd1, 16'h0093, 32'h93);
      hw(1'b1, 4'd0, 32'h0099);
      sync();
      hw(1'b1, 4'd0, 32'h9999);
      check_issue("R11 entry0", 16'h0091, 32'h91);
      step(); check_issue("R11 imm first", 16'h0099, 32'h9999);
      step(); check_issue("R11 entry1", 16'h0092, 32'h92);
      step(); check_issue("R11 entry2", 16'h0093, 32'h93);
      step(); check("R11 done", {63'd0, out_we}, 64'd0);
   endtask

   initial begin
      #100000;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; host_we = 1'b0; host_rel = 1'b0; host_slot = '0;
      host_word = '0; frame_sync = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_run();
      t_absolute();
      t_relative();
      t_immediate();
      t_wrap();
      t_stopped();
      t_overflow();
      t_priority();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule